// File: doc/BRIEF.md
# SHA-256 Block Compression Engine

This block is a register-mapped hash engine. It folds one 512-bit message block at a time into a single running SHA-256 state. Software writes sixteen 32-bit words into a data window at word addresses 0 to 15. It then writes a command to word address 16. A start command begins from the standard initial hash values, which the hardware holds itself. A continue command chains from the state left by the previous block. Software polls the busy bit and then reads the 256-bit digest from word addresses 0 to 7, the same registers that held the input.

The engine applies no message padding. Software must append the 0x80 byte, the zero fill and the 64-bit big-endian bit length to the last block itself. Only one hash context exists, and its intermediate state can be neither read nor reloaded. As a result, only one message can be in progress at a time.

Each compression runs 64 rounds at one round per clock. The message schedule is derived on the fly from a 16-word sliding window, and one further cycle adds the result into the state. The bus answers every selected access one cycle later: busReady is high for that cycle, and for reads busRdata carries the data in the same cycle.

Top module: `sha256_blk_accel`

## Requirements
- R1: After a synchronous reset, every window word (addresses 0 to 15) and the status word (address 16) read as zero.
- R2: A selected access sampled at a clock edge raises busReady in the following cycle. A read returns the addressed word in that same cycle. A window write made while idle is stored and can be read back.
- R3: Writing code 01 to bits 1:0 of address 16 while idle starts a new hash from the standard initial values (h0 = 0x6a09e667). Codes 00 and 11 have no effect.
- R4: Bit 0 of a read of address 16 is the busy flag. After an accepted command, it reads 1 on exactly the 65 bus cycles that follow the command cycle, and 0 from then on.
- R5: On completion, words 0 to 7 hold H0 to H7 of the new state and words 8 to 15 keep their input values. The single padded block for the message bytes 30 00 00 00 gives 4F8320D9 1E97D546 DC799848 E8D218E1 8050AF7A 7964E041 4DE9E547 9006D7E3.
- R6: Code 10 (continue) adds the new block's compression onto the hidden state, which is not taken from the window. A 64-byte message of 0x30 bytes, given as two blocks (start, then continue), gives 60E05BD1 B195AF2F 94112FA7 197A5C88 28905884 0CE7C6DF 9693756B C6250F55.
- R7: Words are big-endian, with the first message byte in bits 31:24 of word 0. The block is hashed exactly as written, with no padding added. Thirty-two bytes of 0x30, padded by software into one block, give 84E0C0EA FAA95A34 C293F278 AC52E45C E537BAB5 E752A00E 6959A13A E103B65A.
- R8: Window writes made while busy are ignored. This includes a write sampled on the same edge at which the digest is written back.
- R9: Commands written while busy are ignored and do not lengthen the busy period.
- R10: A continue command issued when no start has been accepted since reset is ignored, and busy stays 0.
- R11: Reads of the window while busy return its last stable contents, which are the input words of the running block.
- R12: Addresses 17 to 31 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busSel | input | 1 | Access request for this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busReady is high |
| busReady | output | 1 | Access acknowledge, one cycle after busSel |

## Verification
The digest writeback into words 0 to 7 and a software access to the window can fall on the same clock edge: the last busy cycle is the one in which the final state addition lands. The bench provokes this by counting exactly 64 status reads after a start and then placing a window write on the 65th cycle, followed by another write on the next cycle. A cycle-accurate behavioural model judges the result. The first write must be lost, the second must be kept, and the digest must be unaffected.

// File: rtl/sha256_pkg.sv
package sha256_pkg;
  localparam int WORD_W     = 32;
  localparam int BLK_WORDS  = 16;
  localparam int HASH_WORDS = 8;
  localparam int NUM_ROUNDS = 64;
  localparam int IDX_W      = $clog2(BLK_WORDS);
  localparam int RIDX_W     = $clog2(NUM_ROUNDS);
  localparam int CNT_W      = $clog2(NUM_ROUNDS + 1);

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_START = 2'b01,
    CMD_CONT  = 2'b10,
    CMD_RSVD  = 2'b11
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              winWe;
    logic [IDX_W-1:0]  winIdx;
    logic              loadInit;
    logic              loadChain;
    logic              roundEn;
    logic [RIDX_W-1:0] roundIdx;
    logic              finish;
  } strobe_t;

  localparam word_t INIT_H [HASH_WORDS] = '{
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
  };

  localparam word_t ROUND_K [NUM_ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
    32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
    32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
    32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
    32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
    32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
    32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
    32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
    32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t bigSig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t bigSig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t smSig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t smSig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t chooseFn(input word_t e, input word_t f, input word_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic word_t majFn(input word_t a, input word_t b, input word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction
endpackage

// File: rtl/sha256_ctrl.sv
module sha256_ctrl
  import sha256_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        cmdBits,
  input  word_t             winRd,
  output strobe_t           strb,
  output word_t             busRdata,
  output logic              busReady
);
  localparam int CMD_ADDR = BLK_WORDS;

  logic             busyQ;
  logic             hasCtxQ;
  logic [CNT_W-1:0] cntQ;
  word_t            rdQ;
  logic             readyQ;

  logic isWr, hitWin, hitCmd, goStart, goCont, lastRound;
  cmd_e cmdCode;

  assign isWr      = busSel && busWe;
  assign hitWin    = busAddr < ADDR_W'(BLK_WORDS);
  assign hitCmd    = busAddr == ADDR_W'(CMD_ADDR);
  assign cmdCode   = cmd_e'(cmdBits);
  assign goStart   = isWr && hitCmd && !busyQ && (cmdCode == CMD_START);
  assign goCont    = isWr && hitCmd && !busyQ && (cmdCode == CMD_CONT) && hasCtxQ;
  assign lastRound = cntQ == CNT_W'(NUM_ROUNDS);

  always_comb begin
    strb           = '0;
    strb.winWe     = isWr && hitWin && !busyQ;
    strb.winIdx    = busAddr[IDX_W-1:0];
    strb.loadInit  = goStart;
    strb.loadChain = goCont;
    strb.roundEn   = busyQ && !lastRound;
    strb.roundIdx  = cntQ[RIDX_W-1:0];
    strb.finish    = busyQ && lastRound;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ   <= 1'b0;
      hasCtxQ <= 1'b0;
      cntQ    <= '0;
    end else if (goStart || goCont) begin
      busyQ <= 1'b1;
      cntQ  <= '0;
      if (goStart) hasCtxQ <= 1'b1;
    end else if (busyQ) begin
      if (lastRound) busyQ <= 1'b0;
      else           cntQ  <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdQ    <= '0;
      readyQ <= 1'b0;
    end else begin
      readyQ <= busSel;
      if (busSel) begin
        if (hitWin)      rdQ <= winRd;
        else if (hitCmd) rdQ <= {{(WORD_W-1){1'b0}}, busyQ};
        else             rdQ <= '0;
      end
    end
  end

  assign busRdata = rdQ;
  assign busReady = readyQ;

  AST_READY_NEXT: assert property (@(posedge clk) disable iff (rst)
    busSel |=> busReady); // R2
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(busyQ) |-> $past(isWr && hitCmd)); // R4
  AST_ROUND_STEP: assert property (@(posedge clk) disable iff (rst)
    (busyQ && !lastRound) |=> (busyQ && cntQ == $past(cntQ) + 1'b1)); // R9
  AST_NO_CTX_CONT: assert property (@(posedge clk) disable iff (rst)
    (isWr && hitCmd && !busyQ && !hasCtxQ && cmdBits == 2'b10) |=> !busyQ); // R10
endmodule

// File: rtl/sha256_dp.sv
module sha256_dp
  import sha256_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  input  word_t            wrData,
  input  logic [IDX_W-1:0] rdIdx,
  output word_t            winRd
);
  word_t [BLK_WORDS-1:0]  winQ;
  word_t [HASH_WORDS-1:0] stateQ;
  word_t [HASH_WORDS-1:0] wkQ;   // a..h at indices 0..7
  word_t [BLK_WORDS-1:0]  schQ;  // sliding schedule, index 0 = current word
  word_t [HASH_WORDS-1:0] hSum;

  word_t t1, t2, wNext;

  assign t1 = wkQ[7] + bigSig1(wkQ[4]) + chooseFn(wkQ[4], wkQ[5], wkQ[6])
            + ROUND_K[strb.roundIdx] + schQ[0];
  assign t2 = bigSig0(wkQ[0]) + majFn(wkQ[0], wkQ[1], wkQ[2]);
  assign wNext = smSig1(schQ[14]) + schQ[9] + smSig0(schQ[1]) + schQ[0];

  for (genvar g = 0; g < HASH_WORDS; g++) begin : gSum
    assign hSum[g] = stateQ[g] + wkQ[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winQ   <= '0;
      stateQ <= '0;
      wkQ    <= '0;
      schQ   <= '0;
    end else begin
      if (strb.winWe) winQ[strb.winIdx] <= wrData;
      if (strb.loadInit) begin
        for (int i = 0; i < HASH_WORDS; i++) begin
          stateQ[i] <= INIT_H[i];
          wkQ[i]    <= INIT_H[i];
        end
        schQ <= winQ;
      end else if (strb.loadChain) begin
        wkQ  <= stateQ;
        schQ <= winQ;
      end
      if (strb.roundEn) begin
        wkQ[0] <= t1 + t2;
        wkQ[1] <= wkQ[0];
        wkQ[2] <= wkQ[1];
        wkQ[3] <= wkQ[2];
        wkQ[4] <= wkQ[3] + t1;
        wkQ[5] <= wkQ[4];
        wkQ[6] <= wkQ[5];
        wkQ[7] <= wkQ[6];
        schQ   <= {wNext, schQ[BLK_WORDS-1:1]};
      end
      if (strb.finish) begin
        for (int i = 0; i < HASH_WORDS; i++) begin
          stateQ[i] <= hSum[i];
          winQ[i]   <= hSum[i];
        end
      end
    end
  end

  assign winRd = winQ[rdIdx];

  AST_DIGEST_WB: assert property (@(posedge clk) disable iff (rst)
    strb.finish |=> (winQ[HASH_WORDS-1:0] == stateQ)); // R5
  AST_WIN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (strb.roundEn || strb.loadInit || strb.loadChain) |=> $stable(winQ)); // R8
  AST_IV_H0: assert property (@(posedge clk) disable iff (rst)
    strb.loadInit |=> (stateQ[0] == 32'h6a09e667)); // R3
  AST_CHAIN_KEEP: assert property (@(posedge clk) disable iff (rst)
    strb.loadChain |=> $stable(stateQ)); // R6
endmodule

// File: rtl/sha256_blk_accel.sv
module sha256_blk_accel
  import sha256_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busReady
);
  strobe_t strb;
  word_t   winRd;

  sha256_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .busSel   (busSel),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .cmdBits  (busWdata[1:0]),
    .winRd    (winRd),
    .strb     (strb),
    .busRdata (busRdata),
    .busReady (busReady)
  );

  sha256_dp uDp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .wrData (busWdata),
    .rdIdx  (busAddr[IDX_W-1:0]),
    .winRd  (winRd)
  );
endmodule

// File: tb/tb_sha256_blk_accel.sv
module tb_sha256_blk_accel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busReady;

  int nTests = 0;
  int nFail  = 0;

  always #5 clk = ~clk;

  sha256_blk_accel dut (
    .clk(clk), .rst(rst), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busReady(busReady)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] kTab [64];
  logic [31:0] ivTab [8];
  logic [31:0] mWin [16];
  logic [31:0] mBlk [16];
  logic [31:0] mState [8];
  logic        mBusy, mHas;
  int          mCnt;
  logic        expReady;
  logic [31:0] expRd;

  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  task automatic mdlRun();
    logic [31:0] w [64];
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
    for (int t = 0; t < 16; t++) w[t] = mBlk[t];
    for (int t = 16; t < 64; t++)
      w[t] = (ror(w[t-2], 17) ^ ror(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
           + (ror(w[t-15], 7) ^ ror(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
    a = mState[0]; b = mState[1]; c = mState[2]; d = mState[3];
    e = mState[4]; f = mState[5]; g = mState[6]; h = mState[7];
    for (int t = 0; t < 64; t++) begin
      t1 = h + (ror(e, 6) ^ ror(e, 11) ^ ror(e, 25)) + ((e & f) ^ (~e & g)) + kTab[t] + w[t];
      t2 = (ror(a, 2) ^ ror(a, 13) ^ ror(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
      h = g; g = f; f = e; e = d + t1; d = c; c = b; b = a; a = t1 + t2;
    end
    mState[0] += a; mState[1] += b; mState[2] += c; mState[3] += d;
    mState[4] += e; mState[5] += f; mState[6] += g; mState[7] += h;
    for (int i = 0; i < 8; i++) mWin[i] = mState[i];
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) mWin[i] = '0;
      for (int i = 0; i < 8; i++) mState[i] = '0;
      mBusy = 1'b0; mHas = 1'b0; mCnt = 0;
      expReady = 1'b0; expRd = '0;
    end else begin
      expReady = busSel;
      if (busSel) begin
        if (busAddr < 5'd16)       expRd = mWin[busAddr[3:0]];
        else if (busAddr == 5'd16) expRd = {31'b0, mBusy};
        else                       expRd = '0;
      end
      if (mBusy) begin
        mCnt++;
        if (mCnt == 65) begin
          mdlRun();
          mBusy = 1'b0;
        end
      end else if (busSel && busWe) begin
        if (busAddr < 5'd16) mWin[busAddr[3:0]] = busWdata;
        else if (busAddr == 5'd16) begin
          if (busWdata[1:0] == 2'b01) begin
            for (int i = 0; i < 8; i++) mState[i] = ivTab[i];
            for (int i = 0; i < 16; i++) mBlk[i] = mWin[i];
            mBusy = 1'b1; mCnt = 0; mHas = 1'b1;
          end else if (busWdata[1:0] == 2'b10 && mHas) begin
            for (int i = 0; i < 16; i++) mBlk[i] = mWin[i];
            mBusy = 1'b1; mCnt = 0;
          end
        end
      end
    end
  end

  // every-clock comparison against the model (R2 bus behaviour)
  always @(negedge clk) begin
    if (!rst) begin
      nTests++;
      if (busReady !== expReady) begin
        nFail++;
        $display("FAIL R2 ready act=%0b exp=%0b", busReady, expReady);
      end else if (expReady && busRdata !== expRd) begin
        nFail++;
        $display("FAIL R2 model read act=%08h exp=%08h", busRdata, expRd);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  logic [31:0] blkBuf [16];
  logic [31:0] rd;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [4:0] a, input logic [31:0] d,
                      output logic [31:0] r);
    busSel = 1'b1; busWe = we; busAddr = a; busWdata = d;
    @(negedge clk);
    r = busRdata;
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic writeBuf();
    logic [31:0] dummy;
    for (int i = 0; i < 16; i++) xfer(1'b1, 5'(i), blkBuf[i], dummy);
  endtask

  task automatic waitIdle(output int n);
    logic [31:0] r;
    n = 0;
    for (int k = 0; k < 300; k++) begin
      xfer(1'b0, 5'd16, '0, r);
      if (r[0] !== 1'b1) break;
      n++;
    end
  endtask

  task automatic checkDigest(input string tag, input logic [31:0] e0, e1, e2, e3,
                             e4, e5, e6, e7);
    logic [31:0] ex [8];
    logic [31:0] r;
    ex = '{e0, e1, e2, e3, e4, e5, e6, e7};
    for (int i = 0; i < 8; i++) begin
      xfer(1'b0, 5'(i), '0, r);
      check(tag, r, ex[i]);
    end
  endtask

  task automatic loadVecA();
    for (int i = 0; i < 16; i++) blkBuf[i] = '0;
    blkBuf[0] = 32'h30000000; blkBuf[1] = 32'h80000000; blkBuf[15] = 32'd32;
  endtask

  initial begin
    int cntP, n;
    real rc;
    logic [63:0] tmp;
    cntP = 0;
    for (int p = 2; cntP < 64; p++) begin
      automatic bit isPr;
      isPr = 1'b1;
      for (int q = 2; q * q <= p; q++) if (p % q == 0) isPr = 1'b0;
      if (isPr) begin
        rc = $pow(real'(p), 1.0 / 3.0);
        tmp = longint'($floor((rc - $floor(rc)) * 4294967296.0));
        kTab[cntP] = tmp[31:0];
        if (cntP < 8) begin
          rc = $sqrt(real'(p));
          tmp = longint'($floor((rc - $floor(rc)) * 4294967296.0));
          ivTab[cntP] = tmp[31:0];
        end
        cntP++;
      end
    end

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int i = 0; i <= 16; i++) begin
      xfer(1'b0, 5'(i), '0, rd);
      check("R1 reset read", rd, 32'h0);
    end

    // R10: continue with no context
    xfer(1'b1, 5'd16, 32'h2, rd);
    xfer(1'b0, 5'd16, '0, rd);
    check("R10 continue before start", rd, 32'h0);

    // R12: out-of-window addresses
    xfer(1'b1, 5'd20, 32'hFFFFFFFF, rd);
    xfer(1'b0, 5'd20, '0, rd);
    check("R12 high address", rd, 32'h0);
    xfer(1'b0, 5'd31, '0, rd);
    check("R12 top address", rd, 32'h0);

    // vector A, one block
    loadVecA();
    writeBuf();
    xfer(1'b0, 5'd0, '0, rd);  check("R2 readback w0", rd, 32'h30000000);
    xfer(1'b0, 5'd15, '0, rd); check("R2 readback w15", rd, 32'd32);
    // R3: codes 00 and 11 do nothing
    xfer(1'b1, 5'd16, 32'h3, rd);
    xfer(1'b1, 5'd16, 32'h0, rd);
    xfer(1'b0, 5'd16, '0, rd);
    check("R3 reserved code", rd, 32'h0);
    xfer(1'b1, 5'd16, 32'h1, rd);
    waitIdle(n);
    check("R4 busy length", 32'(n), 32'd65);
    checkDigest("R5 one-block digest", 32'h4F8320D9, 32'h1E97D546, 32'hDC799848,
                32'hE8D218E1, 32'h8050AF7A, 32'h7964E041, 32'h4DE9E547, 32'h9006D7E3);
    xfer(1'b0, 5'd15, '0, rd); check("R5 input words kept", rd, 32'd32);
    xfer(1'b0, 5'd1, '0, rd);  check("R5 digest over input", rd, 32'h1E97D546);

    // vector B with busy-time interference
    for (int i = 0; i < 16; i++) blkBuf[i] = (i < 8) ? 32'h30303030 : 32'h0;
    blkBuf[8] = 32'h80000000; blkBuf[15] = 32'd256;
    writeBuf();
    xfer(1'b1, 5'd16, 32'h1, rd);             // E0
    xfer(1'b0, 5'd5, '0, rd);                 // E1
    check("R11 read while busy", rd, 32'h30303030);
    xfer(1'b1, 5'd12, 32'hDEADBEEF, rd);      // E2, ignored
    xfer(1'b1, 5'd16, 32'h1, rd);             // E3, ignored
    waitIdle(n);
    check("R9 command while busy", 32'(n), 32'd62);
    checkDigest("R7 byte order digest", 32'h84E0C0EA, 32'hFAA95A34, 32'hC293F278,
                32'hAC52E45C, 32'hE537BAB5, 32'hE752A00E, 32'h6959A13A, 32'hE103B65A);
    xfer(1'b0, 5'd12, '0, rd);
    check("R8 write while busy", rd, 32'h0);

    // chained two-block message, completion-edge collision
    for (int i = 0; i < 16; i++) blkBuf[i] = 32'h30303030;
    writeBuf();
    xfer(1'b1, 5'd16, 32'h1, rd);             // E0
    n = 0;
    for (int k = 0; k < 64; k++) begin        // E1..E64
      xfer(1'b0, 5'd16, '0, rd);
      if (rd[0] === 1'b1) n++;
    end
    check("R4 busy through rounds", 32'(n), 32'd64);
    xfer(1'b1, 5'd12, 32'h12345678, rd);      // E65, finish edge
    xfer(1'b1, 5'd13, 32'hCAFEF00D, rd);      // E66, idle
    xfer(1'b0, 5'd12, '0, rd);
    check("R8 write on completion edge", rd, 32'h30303030);
    xfer(1'b0, 5'd13, '0, rd);
    check("R2 write first idle cycle", rd, 32'hCAFEF00D);
    for (int i = 0; i < 16; i++) blkBuf[i] = '0;
    blkBuf[0] = 32'h80000000; blkBuf[15] = 32'd512;
    writeBuf();
    xfer(1'b1, 5'd16, 32'h2, rd);
    waitIdle(n);
    check("R6 continue busy length", 32'(n), 32'd65);
    checkDigest("R6 chained digest", 32'h60E05BD1, 32'hB195AF2F, 32'h94112FA7,
                32'h197A5C88, 32'h28905884, 32'h0CE7C6DF, 32'h9693756B, 32'hC6250F55);

    // R3: a fresh start re-initialises after chaining
    loadVecA();
    writeBuf();
    xfer(1'b1, 5'd16, 32'h1, rd);
    waitIdle(n);
    checkDigest("R3 restart digest", 32'h4F8320D9, 32'h1E97D546, 32'hDC799848,
                32'hE8D218E1, 32'h8050AF7A, 32'h7964E041, 32'h4DE9E547, 32'h9006D7E3);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule